// File: doc/BRIEF.md
# Timer interrupt flag controller

This block keeps the five interrupt request flags of a real-time clock timer. Four flags follow periodic square-wave taps of the timer's frequency divider (32 Hz, 8 Hz, 2 Hz and 1 Hz). A fifth flag records a one-cycle overflow pulse from the minute counter. A flag sets on its event whatever the enable and priority settings are. Software sees all five flags in one 8-bit flag word and clears them by writing ones to it.

An interrupt request is raised while any flag is set and its enable bit is on, provided the shared two-bit priority is strictly above the CPU's current two-bit mask level. The enable bits, the priority and the mask arrive as inputs from the surrounding register file and CPU core. The taps and the overflow pulse are assumed to be synchronous to `clk`.

Top module: `tif_ctrl`

## Requirements
- R1: In the flag word, the 32 Hz flag is bit 3, the 8 Hz flag bit 4, the 2 Hz flag bit 5, the 1 Hz flag bit 6 and the minute flag bit 7. Bits 2:0 always read 0. Tap input bits 0..3 and enable bits 0..3 follow the same source order, and enable bit 4 belongs to the minute flag.
- R2: A periodic flag reads 1 after the first clock edge at which its tap is sampled low following a sample high.
- R3: The minute flag reads 1 after any clock edge at which the overflow pulse is sampled high.
- R4: Flags set on their events whatever the enable, priority and mask inputs are.
- R5: A write with a 1 in a flag's bit position clears that flag at that clock edge.
- R6: A 0 written to a flag's bit position leaves that flag unchanged, and so does a write to bits 2:0.
- R7: When a set event and a clearing write hit the same flag at the same edge, the flag ends up 1.
- R8: The request output is 1 exactly when some flag is 1 with its enable bit 1 and the priority input is strictly greater than the mask input (unsigned). It follows the inputs combinationally.
- R9: All flags read 0 during reset and after it, until an event occurs.
- R10: A rising edge on a tap, or a tap held at a steady level, does not set its flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tap_i | input | 4 | Divider taps: bit 0 = 32 Hz, bit 1 = 8 Hz, bit 2 = 2 Hz, bit 3 = 1 Hz |
| min_ovf_i | input | 1 | One-cycle minute counter overflow pulse |
| wr_en_i | input | 1 | Write strobe to the flag word |
| wr_data_i | input | 8 | Write data; a 1 in bits 7:3 clears the matching flag |
| irq_en_i | input | 5 | Per-source enable bits in source order (bit 4 = minute) |
| irq_pri_i | input | 2 | Shared priority level of the timer interrupt |
| cpu_mask_i | input | 2 | CPU's current interrupt mask level |
| flags_o | output | 8 | Flag word (bits 7:3 flags, bits 2:0 zero) |
| irq_o | output | 1 | Interrupt request |

## Verification
Each tap is driven through a falling edge, a rising edge and a steady level, so that an edge detector that fires on the wrong edge, or on a level, shows up as a wrong flag. Clearing writes are tried with all-ones, single-bit, zero and low-bits-only data, to tell a write-1 clear apart from a write-0 clear and from a plain overwrite. A set and a clear are made to hit the same flag at the same edge to expose the wrong priority. The request is swept through mask values below, equal to and above the priority, with the enables on and off, which separates a strict compare from a non-strict one. A long pseudo-random stretch then mixes all the inputs, and a behavioural model is compared with the outputs on every cycle.

// File: rtl/tif_pkg.sv
// Package: shared sizes for the timer interrupt flag controller.
// Assumes the flag word puts the periodic flags just below the minute flag.
package tif_pkg;
    parameter int TIF_TAPS     = 4;                // periodic sources
    parameter int TIF_SRCS     = TIF_TAPS + 1;     // plus minute overflow
    parameter int TIF_PRI_W    = 2;                // priority / mask width
    parameter int TIF_WORD_W   = 8;                // flag word width
    parameter int TIF_FLAG_LSB = TIF_WORD_W - TIF_SRCS; // first flag bit
endpackage

// File: rtl/tif_edge_det.sv
// Falling-edge detector, one lane per divider tap.
// Assumes the taps are synchronous to clk. The history register follows the
// taps even during reset, so a fall in the first cycle after reset is seen.
module tif_edge_det #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic [N-1:0] tap_i,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] prev_q;

    // Keep last cycle's sample of each tap.
    always_ff @(posedge clk) begin
        prev_q <= tap_i;
    end

    for (genvar g = 0; g < N; g++) begin : g_lane
        // High last cycle and low now marks a falling edge.
        always_comb fall_o[g] = prev_q[g] & ~tap_i[g];
    end
endmodule

// File: rtl/tif_flag_bank.sv
// Flag storage: each flag sets on its event and clears on a write of 1.
// Assumes set_i and clr_i are single-cycle qualified strobes; set has priority.
module tif_flag_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_q;

    for (genvar g = 0; g < N; g++) begin : g_flag
        // Update one flag: reset to 0, set wins over clear, else hold.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q[g] <= 1'b0;
            else if (set_i[g])
                flag_q[g] <= 1'b1;
            else if (clr_i[g])
                flag_q[g] <= 1'b0;
        end

        // R5: a clear with no competing set empties the flag.
        a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !flag_q[g]);
        // R7: a set event always leaves the flag at 1, even under a clear.
        a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> flag_q[g]);
        // R6: with no set and no clear the flag keeps its value.
        a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_i[g] && !clr_i[g]) |=> $stable(flag_q[g]));
    end

    always_comb flag_o = flag_q;
endmodule

// File: rtl/tif_req_gen.sv
// Request generator: masks flags with enables and compares priority with the
// CPU mask level. Purely combinational; assumes both levels are unsigned.
module tif_req_gen #(
    parameter int N     = 5,
    parameter int PRI_W = 2
) (
    input  logic [N-1:0]     flag_i,
    input  logic [N-1:0]     en_i,
    input  logic [PRI_W-1:0] pri_i,
    input  logic [PRI_W-1:0] mask_i,
    output logic             irq_o
);
    logic any_live;
    logic pri_above;

    // Any flag whose source is enabled.
    always_comb any_live = |(flag_i & en_i);
    // Priority must be strictly above the current mask level.
    always_comb pri_above = (pri_i > mask_i);
    // Raise the request only when both hold.
    always_comb irq_o = any_live & pri_above;
endmodule

// File: rtl/tif_ctrl.sv
// Top: timer interrupt flag controller. Detects tap falls, stores five flags,
// decodes write-1 clears from the flag word and forms the interrupt request.
// Assumes taps, the overflow pulse and writes are synchronous to clk.
module tif_ctrl
    import tif_pkg::*;
#(
    parameter int TAPS     = TIF_TAPS,
    parameter int PRI_W    = TIF_PRI_W,
    parameter int WORD_W   = TIF_WORD_W,
    localparam int SRCS     = TAPS + 1,
    localparam int FLAG_LSB = WORD_W - SRCS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAPS-1:0]   tap_i,
    input  logic              min_ovf_i,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic [SRCS-1:0]   irq_en_i,
    input  logic [PRI_W-1:0]  irq_pri_i,
    input  logic [PRI_W-1:0]  cpu_mask_i,
    output logic [WORD_W-1:0] flags_o,
    output logic              irq_o
);
    logic [TAPS-1:0] fall;
    logic [SRCS-1:0] set_ev;
    logic [SRCS-1:0] clr_ev;
    logic [SRCS-1:0] flag;

    tif_edge_det #(.N(TAPS)) u_edge (
        .clk    (clk),
        .tap_i  (tap_i),
        .fall_o (fall)
    );

    // Gather set events: tap falls below, minute overflow on top.
    always_comb set_ev = {min_ovf_i, fall};
    // Write-1 clear strobes taken from the flag field of the write data.
    always_comb clr_ev = wr_en_i ? wr_data_i[WORD_W-1:FLAG_LSB] : '0;

    tif_flag_bank #(.N(SRCS)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_ev),
        .clr_i  (clr_ev),
        .flag_o (flag)
    );

    tif_req_gen #(.N(SRCS), .PRI_W(PRI_W)) u_req (
        .flag_i (flag),
        .en_i   (irq_en_i),
        .pri_i  (irq_pri_i),
        .mask_i (cpu_mask_i),
        .irq_o  (irq_o)
    );

    // Place the flags in the upper bits; unused low bits read 0.
    always_comb begin
        flags_o = '0;
        flags_o[WORD_W-1:FLAG_LSB] = flag;
    end

    for (genvar k = 0; k < TAPS; k++) begin : g_chk
        // R2: a sampled fall on a tap shows as its flag after the edge.
        a_r2_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(tap_i[k]) |=> flags_o[FLAG_LSB+k]);
    end

    // R3: an overflow pulse sets the minute flag.
    a_r3_minute_sets: assert property (@(posedge clk) disable iff (!rst_n)
        min_ovf_i |=> flags_o[WORD_W-1]);
    // R8: a request never appears unless priority beats the mask.
    a_r8_strict_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_pri_i > cpu_mask_i));
    // R9: the first cycle after reset shows an empty flag word.
    a_r9_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (flags_o == '0));
endmodule

// File: tb/tb_tif_ctrl.sv
// Bench for tif_ctrl: directed checks plus a behavioural model compared on
// every clock. Inputs change 3 ns after a rising edge; the model updates at
// the edge and outputs are compared 2 ns after it.
module tb_tif_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] tap_i = 4'hF;
    logic       min_ovf_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [4:0] irq_en_i = 5'h00;
    logic [1:0] irq_pri_i = 2'd0;
    logic [1:0] cpu_mask_i = 2'd0;
    logic [7:0] flags_o;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    int m_flag [5];
    int m_prev [4];

    always #5 clk = ~clk;

    tif_ctrl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tap_i      (tap_i),
        .min_ovf_i  (min_ovf_i),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .irq_en_i   (irq_en_i),
        .irq_pri_i  (irq_pri_i),
        .cpu_mask_i (cpu_mask_i),
        .flags_o    (flags_o),
        .irq_o      (irq_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_word();
        int w = 0;
        for (int i = 0; i < 5; i++) if (m_flag[i] != 0) w += (1 << (i + 3));
        return w;
    endfunction

    function automatic int model_irq();
        int live = 0;
        for (int i = 0; i < 5; i++) if (m_flag[i] != 0 && irq_en_i[i]) live = 1;
        return (live != 0 && int'(irq_pri_i) > int'(cpu_mask_i)) ? 1 : 0;
    endfunction

    // Reference model: update at each edge, then compare shortly after.
    always @(posedge clk) begin
        int set_e, clr_e;
        cycles++;
        for (int i = 0; i < 5; i++) begin
            if (!rst_n) m_flag[i] = 0;
            else begin
                set_e = (i < 4) ? ((m_prev[i] != 0 && !tap_i[i]) ? 1 : 0) : int'(min_ovf_i);
                clr_e = (wr_en_i && wr_data_i[i + 3]) ? 1 : 0;
                if (set_e != 0) m_flag[i] = 1;
                else if (clr_e != 0) m_flag[i] = 0;
            end
        end
        for (int i = 0; i < 4; i++) m_prev[i] = int'(tap_i[i]);
        #2;
        check("R4 model flags", int'(flags_o), model_word());
        check("R8 model irq", int'(irq_o), model_irq());
    end

    // Watchdog.
    initial begin
        wait (cycles > 20000 || done);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #3;
    endtask

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        for (int i = 0; i < 5; i++) m_flag[i] = 0;
        for (int i = 0; i < 4; i++) m_prev[i] = 1;
        tick(); tick(); tick();
        check("R9 reset word", int'(flags_o), 0);
        rst_n = 1'b1;
        tick(); tick();
        check("R10 steady high", int'(flags_o), 0);
        check("R9 after reset", int'(flags_o), 0);

        // R2 / R4: 32 Hz falls with everything disabled.
        tap_i[0] = 1'b0;
        tick();
        check("R2 32Hz fall", int'(flags_o), 8'h08);
        check("R4 irq off while disabled", int'(irq_o), 0);

        // R5: clear by writing 1.
        wr_en_i = 1'b1; wr_data_i = 8'h08;
        tick();
        wr_en_i = 1'b0;
        check("R5 write-1 clear", int'(flags_o), 0);
        tap_i[0] = 1'b1;
        tick(); tick();
        check("R10 rising edge", int'(flags_o), 0);

        // R3: minute overflow pulse sets bit 7.
        min_ovf_i = 1'b1;
        tick();
        min_ovf_i = 1'b0;
        check("R3 minute flag", int'(flags_o), 8'h80);

        // R6: zero in bit 7 and low-bit writes keep it.
        wr_en_i = 1'b1; wr_data_i = 8'h7F;
        tick();
        wr_en_i = 1'b0;
        check("R6 zero write keeps", int'(flags_o), 8'h80);

        // R8: priority vs mask sweep, minute source enabled.
        irq_en_i = 5'h10; irq_pri_i = 2'd2; cpu_mask_i = 2'd1;
        #1 check("R8 pri above mask", int'(irq_o), 1);
        cpu_mask_i = 2'd2;
        #1 check("R8 pri equal mask", int'(irq_o), 0);
        cpu_mask_i = 2'd3;
        #1 check("R8 pri below mask", int'(irq_o), 0);
        irq_pri_i = 2'd3; cpu_mask_i = 2'd2;
        #1 check("R8 top pri", int'(irq_o), 1);
        irq_en_i = 5'h0F;
        #1 check("R8 other enables only", int'(irq_o), 0);
        irq_en_i = 5'h00;

        // R7: fall on 8 Hz with clear of the same bit.
        tap_i[1] = 1'b0; wr_en_i = 1'b1; wr_data_i = 8'h10;
        tick();
        wr_en_i = 1'b0;
        check("R7 set beats clear", int'(flags_o), 8'h90);

        // R1: 2 Hz and 1 Hz positions.
        tap_i[2] = 1'b0; tap_i[3] = 1'b0;
        tick();
        check("R1 bit layout", int'(flags_o), 8'hF0);
        wr_en_i = 1'b1; wr_data_i = 8'hFF;
        tick();
        wr_en_i = 1'b0;
        check("R5 clear all", int'(flags_o), 0);
        tick();
        check("R10 steady low", int'(flags_o), 0);

        // Mixed pseudo-random stretch against the model.
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tap_i      = lfsr[3:0];
            min_ovf_i  = (lfsr[6:4] == 3'd0);
            wr_en_i    = lfsr[7];
            wr_data_i  = {lfsr[12:8], lfsr[2:0]};
            irq_en_i   = lfsr[15:11];
            irq_pri_i  = lfsr[10:9];
            cpu_mask_i = lfsr[5:4];
            tick();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule